// File: doc/BRIEF.md
# Gate Schedule Configuration Register Bank

This block holds the configuration that a time-aware transmit gate scheduler runs from. Software reaches it over a simple 32-bit register bus with an address, a write strobe, write data, a read strobe and read data. Most configuration is written indirectly. Software first places a word in a staging register. It then writes a transfer-control register with a start bit set. The control word chooses one of two targets: an entry of the gate-control list, or one of six schedule parameter words. The transfer completes a fixed number of clocks later, and the block then clears the start bit. Software polls the start bit to know when the transfer is done.

The gate-control list is double-buffered. Indirect list writes always land in the shadow bank, while the scheduler reads the active bank through a combinational read port. A bank switch requested by software takes effect at the next cycle-boundary pulse from the scheduler. The block also holds the scheduler run control: an enable bit and a 9-bit time-offset value. A read-only capability word is built from the parameters.

Top module: `gsched_cfg_bank`

## Requirements
- R1: After reset every register reads zero (except the capability word), all schedule outputs are zero, sched_en_o is 0 and active_bank_o is 0.
- R2: The capability word reads as follows. Bit 19 is 1. Bits 22:20 hold clog2(DEPTH)-5, clamped to the range 0..7. Bits 24:23 hold an entry-width code: 0 for up to 16 bits, 1 for up to 20, 2 for up to 24, and 3 otherwise. All other bits are 0. The default value is 0x01980000. Bus writes to this word have no effect.
- R3: Writing the transfer-control word with bit 0 set starts a transfer. Bit 0 then reads 1 on reads sampled at the first, second and third clock edges after the write edge. The target is updated on the third edge, and bit 0 reads 0 from the fourth read on.
- R4: With transfer-control bit 2 set to 1, the field in bits 23:8 selects a parameter word: 0 base time low, 1 base time high, 2 cycle time low, 3 cycle time high, 4 time extension, 5 list length. base_time_o is {1,0}, cycle_time_o is {3,2}, time_ext_o is word 4 and list_len_o is word 5. A parameter index above 5 is dropped and changes no output.
- R5: With bit 2 set to 0, the staged value (its low ENTRY_W bits) is written at the list index in bits 23:8 of the shadow bank. The active bank seen on gcl_rd_data_o does not change until a swap.
- R6: While a transfer is in progress, bus writes to the staging register and to the transfer-control word are ignored.
- R7: A list write whose index is DEPTH or more writes no entry and sets sticky bit 3 of the transfer-control word. Writing 1 to bit 3 while idle clears it. Writing 0 to bit 3 leaves it set.
- R8: Scheduler control: bit 0 drives sched_en_o and bits 31:23 drive ptp_offset_o. On readback only bits 31:23, 1 and 0 can be non-zero.
- R9: Writing 1 to scheduler-control bit 1 arms a bank switch. The switch happens on the first cycle_boundary_i pulse sampled after the write edge: active_bank_o toggles and bit 1 clears. Writing 0 does not cancel an armed switch. A boundary pulse with no switch armed changes nothing.
- R10: Word offsets are 0x00 scheduler control, 0x04 transfer control, 0x08 staging data and 0x0C capability. reg_rdata_o is registered: it shows the word addressed at the clock edge that samples reg_rd_i. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe |
| reg_rdata_o | output | 32 | Registered read data |
| cycle_boundary_i | input | 1 | One-cycle pulse at each schedule cycle boundary |
| sched_en_o | output | 1 | Scheduler enable |
| ptp_offset_o | output | 9 | Time-offset value for the scheduler |
| active_bank_o | output | 1 | Index of the list bank in use |
| gcl_rd_idx_i | input | clog2(DEPTH) | Active-list read index |
| gcl_rd_data_o | output | ENTRY_W | Active-list entry at gcl_rd_idx_i |
| base_time_o | output | 64 | Schedule base time |
| cycle_time_o | output | 64 | Schedule cycle time |
| time_ext_o | output | 32 | Cycle time extension |
| list_len_o | output | 32 | Number of list entries in use |

## Verification
The bench reads the start bit on each of the edges around completion and watches base_time_o between them. A design that finished early or late would show the wrong bit or the wrong output on one of those reads. It writes the staging and control words in the middle of a transfer; a design that accepted them would commit the second value or the second target. It writes list entries and then looks at the active port both before and after the boundary pulse. Leaking writes into the active bank would show up there, as would swapping without a pulse, or letting a write of 0 cancel an armed switch. It also writes list index DEPTH and then inspects entry 0 of the bank that was shadow at that time. An index that wrapped instead of being dropped would corrupt that entry, and a missing sticky bit, or one that clears itself, would be caught on the control readback.

// File: rtl/gsched_pkg.sv
package gsched_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned OFF_SCHED = 'h00;
  localparam int unsigned OFF_ICTRL = 'h04;
  localparam int unsigned OFF_IDATA = 'h08;
  localparam int unsigned OFF_CAP   = 'h0C;

  localparam int unsigned IC_START   = 0;
  localparam int unsigned IC_SEL     = 2;
  localparam int unsigned IC_ERR     = 3;
  localparam int unsigned IC_IDX_LSB = 8;
  localparam int unsigned IDX_FLD_W  = 16;

  localparam int unsigned SC_EN      = 0;
  localparam int unsigned SC_SWAP    = 1;
  localparam int unsigned SC_OFS_LSB = 23;
  localparam int unsigned OFS_W      = 9;

  localparam int unsigned NUM_PRM = 6;
  typedef enum logic [2:0] {
    PRM_BASE_LO = 3'd0,
    PRM_BASE_HI = 3'd1,
    PRM_CYC_LO  = 3'd2,
    PRM_CYC_HI  = 3'd3,
    PRM_EXT     = 3'd4,
    PRM_LEN     = 3'd5
  } prm_idx_e;

  typedef struct packed {
    logic                 sel;
    logic [IDX_FLD_W-1:0] idx;
    logic [REG_W-1:0]     data;
  } xfer_t;

  function automatic logic [1:0] width_code(int unsigned ew);
    if (ew <= 16) return 2'd0;
    if (ew <= 20) return 2'd1;
    if (ew <= 24) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [2:0] depth_code(int unsigned depth);
    int unsigned d;
    d = $clog2(depth);
    if (d < 5) return 3'd0;
    if (d > 12) return 3'd7;
    return 3'(d - 5);
  endfunction

  function automatic logic [REG_W-1:0] cap_word(int unsigned ew, int unsigned depth);
    logic [REG_W-1:0] w;
    w        = '0;
    w[24:23] = width_code(ew);
    w[22:20] = depth_code(depth);
    w[19]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/gsched_xfer_ctl.sv
module gsched_xfer_ctl
  import gsched_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LAT   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ictrl_we_i,
  input  logic             idata_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ictrl_rd_o,
  output logic [REG_W-1:0] idata_rd_o,
  output logic             busy_o,
  output logic             commit_o,
  output logic             err_o,
  output xfer_t            xfer_o
);
  localparam int unsigned CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic [REG_W-1:0]     data_q;
  logic                 sel_q;
  logic [IDX_FLD_W-1:0] idx_q;
  logic                 err_q;
  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 commit;
  logic                 oob;

  assign commit = busy_q && (cnt_q == '0);
  assign oob    = !sel_q && (32'(idx_q) >= 32'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      sel_q  <= 1'b0;
      idx_q  <= '0;
      err_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (idata_we_i && !busy_q) data_q <= wdata_i;
      if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (ictrl_we_i) begin
        sel_q <= wdata_i[IC_SEL];
        idx_q <= wdata_i[IC_IDX_LSB +: IDX_FLD_W];
        if (wdata_i[IC_ERR]) err_q <= 1'b0;
        if (wdata_i[IC_START]) begin
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(LAT - 1);
        end
      end
      if (commit && oob) err_q <= 1'b1;
    end
  end

  assign ictrl_rd_o = {8'b0, idx_q, 4'b0, err_q, sel_q, 1'b0, busy_q};
  assign idata_rd_o = data_q;
  assign busy_o     = busy_q;
  assign commit_o   = commit;
  assign err_o      = err_q;
  assign xfer_o     = '{sel: sel_q, idx: idx_q, data: data_q};
endmodule

// File: rtl/gsched_param_bank.sv
module gsched_param_bank
  import gsched_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        commit_i,
  input  xfer_t       xfer_i,
  output logic [63:0] base_time_o,
  output logic [63:0] cycle_time_o,
  output logic [31:0] time_ext_o,
  output logic [31:0] list_len_o
);
  logic [REG_W-1:0] prm [NUM_PRM];

  for (genvar g = 0; g < NUM_PRM; g++) begin : g_prm
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (commit_i && xfer_i.sel && (xfer_i.idx == IDX_FLD_W'(g))) q <= xfer_i.data;
    end
    assign prm[g] = q;
  end

  assign base_time_o  = {prm[PRM_BASE_HI], prm[PRM_BASE_LO]};
  assign cycle_time_o = {prm[PRM_CYC_HI], prm[PRM_CYC_LO]};
  assign time_ext_o   = prm[PRM_EXT];
  assign list_len_o   = prm[PRM_LEN];
endmodule

// File: rtl/gsched_gcl_mem.sv
module gsched_gcl_mem #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned ENTRY_W = 32,
  localparam int unsigned IW     = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_bank_i,
  input  logic [IW-1:0]      wr_idx_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               rd_bank_i,
  input  logic [IW-1:0]      rd_idx_i,
  output logic [ENTRY_W-1:0] rd_data_o
);
  logic [ENTRY_W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [ENTRY_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (wr_en_i && (wr_bank_i == 1'(b))) begin
        mem[wr_idx_i] <= wr_data_i;
      end
    end
    assign bank_rd[b] = mem[rd_idx_i];
  end

  assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/gsched_sched_ctl.sv
module gsched_sched_ctl
  import gsched_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_bit_i,
  input  logic             swap_bit_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic             boundary_i,
  output logic             en_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             pend_o,
  output logic             active_o
);
  logic             en_q;
  logic [OFS_W-1:0] ofs_q;
  logic             pend_q;
  logic             active_q;
  logic             swap;

  assign swap = pend_q && boundary_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      ofs_q    <= '0;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (we_i) begin
        en_q  <= en_bit_i;
        ofs_q <= ofs_i;
      end
      // an armed request is only cleared by the swap itself
      if (swap) begin
        pend_q   <= 1'b0;
        active_q <= ~active_q;
      end else if (we_i && swap_bit_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign en_o     = en_q;
  assign ofs_o    = ofs_q;
  assign pend_o   = pend_q;
  assign active_o = active_q;
endmodule

// File: rtl/gsched_cfg_bank.sv
module gsched_cfg_bank
  import gsched_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DEPTH    = 64,
  parameter int unsigned ENTRY_W  = 32,
  parameter int unsigned XFER_LAT = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        reg_addr_i,
  input  logic                     reg_wr_i,
  input  logic [31:0]              reg_wdata_i,
  input  logic                     reg_rd_i,
  output logic [31:0]              reg_rdata_o,
  input  logic                     cycle_boundary_i,
  output logic                     sched_en_o,
  output logic [8:0]               ptp_offset_o,
  output logic                     active_bank_o,
  input  logic [$clog2(DEPTH)-1:0] gcl_rd_idx_i,
  output logic [ENTRY_W-1:0]       gcl_rd_data_o,
  output logic [63:0]              base_time_o,
  output logic [63:0]              cycle_time_o,
  output logic [31:0]              time_ext_o,
  output logic [31:0]              list_len_o
);
  localparam int unsigned IW = $clog2(DEPTH);
  localparam logic [REG_W-1:0] CAP_WORD = cap_word(ENTRY_W, DEPTH);

  logic             hit_sched, hit_ictrl, hit_idata, hit_cap;
  logic [REG_W-1:0] ictrl_rd, idata_rd, sched_rd, rd_mux, rdata_q;
  logic             busy, commit, err, pend, active;
  xfer_t            xfer;
  logic             list_we;

  assign hit_sched = reg_addr_i == ADDR_W'(OFF_SCHED);
  assign hit_ictrl = reg_addr_i == ADDR_W'(OFF_ICTRL);
  assign hit_idata = reg_addr_i == ADDR_W'(OFF_IDATA);
  assign hit_cap   = reg_addr_i == ADDR_W'(OFF_CAP);

  gsched_xfer_ctl #(.DEPTH(DEPTH), .LAT(XFER_LAT)) u_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ictrl_we_i (reg_wr_i && hit_ictrl),
    .idata_we_i (reg_wr_i && hit_idata),
    .wdata_i    (reg_wdata_i),
    .ictrl_rd_o (ictrl_rd),
    .idata_rd_o (idata_rd),
    .busy_o     (busy),
    .commit_o   (commit),
    .err_o      (err),
    .xfer_o     (xfer)
  );

  gsched_param_bank u_prm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .xfer_i       (xfer),
    .base_time_o  (base_time_o),
    .cycle_time_o (cycle_time_o),
    .time_ext_o   (time_ext_o),
    .list_len_o   (list_len_o)
  );

  gsched_sched_ctl u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_wr_i && hit_sched),
    .en_bit_i   (reg_wdata_i[SC_EN]),
    .swap_bit_i (reg_wdata_i[SC_SWAP]),
    .ofs_i      (reg_wdata_i[SC_OFS_LSB +: OFS_W]),
    .boundary_i (cycle_boundary_i),
    .en_o       (sched_en_o),
    .ofs_o      (ptp_offset_o),
    .pend_o     (pend),
    .active_o   (active)
  );

  assign list_we = commit && !xfer.sel && (32'(xfer.idx) < 32'(DEPTH));

  gsched_gcl_mem #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_gcl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (list_we),
    .wr_bank_i (~active),
    .wr_idx_i  (xfer.idx[IW-1:0]),
    .wr_data_i (xfer.data[ENTRY_W-1:0]),
    .rd_bank_i (active),
    .rd_idx_i  (gcl_rd_idx_i),
    .rd_data_o (gcl_rd_data_o)
  );

  assign active_bank_o = active;
  assign sched_rd = {ptp_offset_o, 21'b0, pend, sched_en_o};

  always_comb begin
    rd_mux = '0;
    if (hit_sched)      rd_mux = sched_rd;
    else if (hit_ictrl) rd_mux = ictrl_rd;
    else if (hit_idata) rd_mux = idata_rd;
    else if (hit_cap)   rd_mux = CAP_WORD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
endmodule

// File: rtl/gsched_cfg_chk.sv
module gsched_cfg_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LAT   = 3
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_i,
  input logic        commit_i,
  input logic        sel_i,
  input logic [15:0] idx_i,
  input logic        err_i,
  input logic [31:0] idata_i,
  input logic        pend_i,
  input logic        active_i,
  input logic        boundary_i,
  input logic        ictrl_we_i,
  input logic        err_clr_bit_i
);
  logic [7:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_i) run_q <= run_q + 8'd1;
    else             run_q <= '0;
  end

  p_commit_on_time_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> run_q == 8'(LAT - 1));

  p_busy_bounded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> run_q <= 8'(LAT - 1));

  p_data_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(idata_i));

  p_ctl_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(idx_i) && $stable(sel_i));

  p_oob_flags_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !sel_i && (32'(idx_i) >= 32'(DEPTH))) |=> err_i);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i && !(ictrl_we_i && err_clr_bit_i && !busy_i)) |=> err_i);

  p_swap_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_i) |-> $past(boundary_i && pend_i));

  p_swap_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && boundary_i) |=> !pend_i && !$stable(active_i));
endmodule

bind gsched_cfg_bank gsched_cfg_chk #(.DEPTH(DEPTH), .LAT(XFER_LAT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (busy),
  .commit_i      (commit),
  .sel_i         (xfer.sel),
  .idx_i         (xfer.idx),
  .err_i         (err),
  .idata_i       (xfer.data),
  .pend_i        (pend),
  .active_i      (active),
  .boundary_i    (cycle_boundary_i),
  .ictrl_we_i    (reg_wr_i && hit_ictrl),
  .err_clr_bit_i (reg_wdata_i[3])
);

// File: tb/gsched_cfg_bank_tb.sv
`timescale 1ns/1ps
module gsched_cfg_bank_tb;
  localparam int DEPTH = 64;
  localparam logic [7:0] A_SCHED = 8'h00, A_ICTRL = 8'h04, A_IDATA = 8'h08, A_CAP = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        boundary = 1'b0;
  logic        sched_en;
  logic [8:0]  ptp_ofs;
  logic        active_bank;
  logic [5:0]  gcl_idx = '0;
  logic [31:0] gcl_data;
  logic [63:0] base_time, cycle_time;
  logic [31:0] time_ext, list_len;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gsched_cfg_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .cycle_boundary_i(boundary), .sched_en_o(sched_en), .ptp_offset_o(ptp_ofs),
    .active_bank_o(active_bank), .gcl_rd_idx_i(gcl_idx), .gcl_rd_data_o(gcl_data),
    .base_time_o(base_time), .cycle_time_o(cycle_time),
    .time_ext_o(time_ext), .list_len_o(list_len)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic xfer(int idx, bit sel, logic [31:0] d);
    logic [31:0] v;
    bit fin = 0;
    wr(A_IDATA, d);
    wr(A_ICTRL, (32'(idx) << 8) | (32'(sel) << 2) | 32'h1);
    for (int i = 0; i < 10 && !fin; i++) begin
      rd(A_ICTRL, v);
      if (!v[0]) fin = 1;
    end
    if (!fin) chk("R3 start bit never cleared", 1, 0);
  endtask

  task automatic pulse_boundary();
    boundary = 1'b1;
    @(posedge clk); @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic gcl_peek(int idx, output logic [31:0] d);
    gcl_idx = 6'(idx);
    #1 d = gcl_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_SCHED, v); chk("R1 sched ctrl reset", v, 0);
    rd(A_ICTRL, v); chk("R1 xfer ctrl reset", v, 0);
    rd(A_IDATA, v); chk("R1 staging reset", v, 0);
    chk("R1 outputs reset", {base_time, cycle_time}, 0);
    chk("R1 ext/len reset", {time_ext, list_len}, 0);
    chk("R1 en/ofs/bank reset", {sched_en, ptp_ofs, active_bank}, 0);
    gcl_peek(0, v); chk("R1 list reset", v, 0);
  endtask

  task automatic t_cap();
    logic [31:0] v;
    rd(A_CAP, v); chk("R2 capability word", v, 32'h0198_0000);
    wr(A_CAP, 32'hFFFF_FFFF);
    rd(A_CAP, v); chk("R2 capability ignores writes", v, 32'h0198_0000);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr(A_IDATA, 32'h1111_2222);
    wr(A_ICTRL, 32'h0000_0005);
    rd(A_ICTRL, v); chk("R3 busy at edge 1", v, 32'h5);
    rd(A_ICTRL, v); chk("R3 busy at edge 2", v, 32'h5);
    chk("R3 target not yet written", base_time, 0);
    rd(A_ICTRL, v); chk("R3 busy at edge 3", v, 32'h5);
    chk("R3 target written at edge 3", base_time, 64'h0000_0000_1111_2222);
    rd(A_ICTRL, v); chk("R3 start cleared", v, 32'h4);
  endtask

  task automatic t_params();
    xfer(1, 1, 32'hA000_0001);
    xfer(2, 1, 32'hB000_0002);
    xfer(3, 1, 32'hB000_0003);
    xfer(4, 1, 32'hC000_0004);
    xfer(5, 1, 32'h0000_0040);
    chk("R4 base time", base_time, 64'hA000_0001_1111_2222);
    chk("R4 cycle time", cycle_time, 64'hB000_0003_B000_0002);
    chk("R4 time extension", time_ext, 32'hC000_0004);
    chk("R4 list length", list_len, 32'h40);
    xfer(6, 1, 32'hDEAD_BEEF);
    chk("R4 index 6 dropped", {base_time, cycle_time}, {64'hA000_0001_1111_2222, 64'hB000_0003_B000_0002});
    chk("R4 index 6 dropped ext/len", {time_ext, list_len}, {32'hC000_0004, 32'h40});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(A_IDATA, 32'hAAAA_0001);
    wr(A_ICTRL, (32'd4 << 8) | 32'h5);
    wr(A_IDATA, 32'hBBBB_0002);
    wr(A_ICTRL, (32'd5 << 8) | 32'h5);
    for (int i = 0; i < 4; i++) rd(A_ICTRL, v);
    chk("R6 committed staged value", time_ext, 32'hAAAA_0001);
    chk("R6 second target untouched", list_len, 32'h40);
    rd(A_IDATA, v); chk("R6 staging write ignored", v, 32'hAAAA_0001);
    rd(A_ICTRL, v); chk("R6 control write ignored", v, (32'd4 << 8) | 32'h4);
  endtask

  task automatic t_sched_ctrl();
    logic [31:0] v;
    wr(A_SCHED, 32'hFF81_2345);
    rd(A_SCHED, v); chk("R8 readback masks", v, 32'hFF80_0001);
    chk("R8 enable and offset", {sched_en, ptp_ofs}, {1'b1, 9'h1FF});
    wr(A_SCHED, 32'h0B80_0000);
    rd(A_SCHED, v); chk("R8 second readback", v, 32'h0B80_0000);
    chk("R8 second enable and offset", {sched_en, ptp_ofs}, {1'b0, 9'h017});
  endtask

  task automatic t_list_swap();
    logic [31:0] v;
    xfer(0, 0, 32'h0A0A_0A0A);
    xfer(5, 0, 32'h0B0B_0B0B);
    xfer(DEPTH-1, 0, 32'h0C0C_0C0C);
    gcl_peek(5, v); chk("R5 shadow write hidden", v, 0);
    pulse_boundary();
    chk("R9 no swap without request", active_bank, 0);
    wr(A_SCHED, 32'h2);
    rd(A_SCHED, v); chk("R9 switch armed", v, 32'h2);
    wr(A_SCHED, 32'h0);
    rd(A_SCHED, v); chk("R9 zero does not cancel", v, 32'h2);
    chk("R9 no swap before pulse", active_bank, 0);
    pulse_boundary();
    chk("R9 swapped on pulse", active_bank, 1);
    rd(A_SCHED, v); chk("R9 switch bit cleared", v, 32'h0);
    gcl_peek(0, v); chk("R5 entry 0 active", v, 32'h0A0A_0A0A);
    gcl_peek(5, v); chk("R5 entry 5 active", v, 32'h0B0B_0B0B);
    gcl_peek(DEPTH-1, v); chk("R5 last entry active", v, 32'h0C0C_0C0C);
    xfer(5, 0, 32'h0D0D_0D0D);
    gcl_peek(5, v); chk("R5 active untouched by new write", v, 32'h0B0B_0B0B);
  endtask

  task automatic t_oob();
    logic [31:0] v;
    xfer(DEPTH, 0, 32'h0E0E_0E0E);
    rd(A_ICTRL, v); chk("R7 error bit set", v, (32'(DEPTH) << 8) | 32'h8);
    wr(A_ICTRL, 32'h0);
    rd(A_ICTRL, v); chk("R7 error bit sticky", v, 32'h8);
    wr(A_ICTRL, 32'h8);
    rd(A_ICTRL, v); chk("R7 error bit cleared", v, 32'h0);
    wr(A_SCHED, 32'h2);
    pulse_boundary();
    chk("R9 swap back", active_bank, 0);
    gcl_peek(0, v); chk("R7 no wrap into entry 0", v, 0);
    gcl_peek(5, v); chk("R5 second bank entry 5", v, 32'h0D0D_0D0D);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(8'h10, v); chk("R10 unmapped reads zero", v, 0);
    reg_addr = A_CAP;
    @(posedge clk); @(negedge clk);
    chk("R10 rdata held without strobe", reg_rdata, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_cap();
    t_latency();
    t_params();
    t_busy_ignore();
    t_sched_ctrl();
    t_list_swap();
    t_oob();
    t_unmapped();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule